// File: doc/BRIEF.md
# RDS Group and Block Synchronizer

This block receives the recovered radio-data bit stream one bit at a time. Each bit comes with a quality flag from the demodulator. The block finds where the 26-bit blocks begin and which block of the group each one is. From then on it delivers one 16-bit data word per block, with the block's identity and a reliability status.

Every block is checked with a syndrome. The block is repaired only when the error is a short burst and every flipped bit was flagged as unreliable. A flywheel keeps alignment through a limited share of bad blocks. The traffic-announcement flag is pulled out of the block that carries it and raises an event when it changes. A software resync input restarts acquisition. It also sends a request to the carrier and bit PLL logic to return to the fastest time constant.

A block is 16 information bits, sent most significant bit first, followed by 10 check bits. The check bits are the remainder of the information times x^10, divided by the generator x^10+x^8+x^7+x^5+x^4+x^3+1. That remainder is XORed with an offset word: A=0x0FC, B=0x198, C=0x168, C'=0x350, D=0x1B4. Because of this, the remainder of a received block equals its offset word when the block has no error.

Top module: `rds_sync`

## Requirements
- R1: While not aligned, a block whose remainder equals any offset word becomes a candidate. If the block that ends exactly 26 valid bits later carries the next offset in group order, `synced` rises. The group order is A→B, B→C or C', C/C'→D, and D→A. The confirming block is output with status 0.
- R2: Two offset-valid blocks that are 26 bits apart but out of group order do not cause alignment, and no word is output.
- R3: While aligned, `word_valid` pulses on the cycle after the 26th bit of each block. The pulse carries the 16 data bits and the identity: 0=A, 1=B, 2=C, 3=C', 4=D. It also carries a status: 0=clean, 1=corrected, 2=uncorrectable.
- R4: A burst error of 5 bits or fewer, whose flipped bits all carry the unreliable flag, is repaired. The word is then output with status 1 and the original data.
- R5: If an error touches any bit flagged reliable, the block is uncorrectable. It gets status 2 and its data is passed on unchanged.
- R6: Alignment is kept while at most 20 of the last 50 aligned blocks were uncorrectable. It is dropped at the block that makes 21.
- R7: A clean or corrected block B whose group-type field (data bits 15:11) is 00000, 00001 or 11111 loads `ta_flag` from data bit 4. When that load changes the flag, `ta_irq` pulses for one cycle.
- R8: `soft_rst` clears alignment, the candidate and the flywheel history. `tc_fast` pulses on the following cycle. `tc_fast` also pulses when the flywheel drops alignment.
- R9: After `rst_n` the block is not aligned, and `word_valid`, `ta_flag`, `ta_irq` and `tc_fast` are all low.
- R10: In the C slot, a block carrying offset C' is reported with identity 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | A new stream bit is present |
| bit_in | input | 1 | Stream bit |
| bit_bad | input | 1 | Bit flagged unreliable by the demodulator |
| soft_rst | input | 1 | Software resync request |
| word_valid | output | 1 | Block word output strobe |
| word_data | output | 16 | Block data, corrected when possible |
| word_id | output | 3 | Block identity |
| word_status | output | 2 | Block reliability status |
| synced | output | 1 | Group and block alignment held |
| ta_flag | output | 1 | Current traffic-announcement flag |
| ta_irq | output | 1 | One-cycle pulse when the flag changes |
| tc_fast | output | 1 | Request to reset the PLL time constants to the fastest setting |

## Verification
The in-line assertions check several rules on every cycle. The status and identity codes must stay legal. The bad-block count of an aligned stream never exceeds the limit. A resync is followed by loss of alignment and a time-constant request. Every flag event matches a real change of the flag. Every rise of alignment comes with a clean word. Only the bench scenarios can show the rest, because they need whole encoded blocks: rejection of out-of-order offsets, recovery of the exact data after a flagged burst, refusal to repair an error that touches a reliable bit, the C' identity, and the exact block at which the flywheel gives up.

// File: rtl/rds_sync.sv
module rds_sync #(
  parameter int WIN     = 50,
  parameter int MAX_BAD = 20,
  parameter int BURST   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_valid,
  input  logic        bit_in,
  input  logic        bit_bad,
  input  logic        soft_rst,
  output logic        word_valid,
  output logic [15:0] word_data,
  output logic [2:0]  word_id,
  output logic [1:0]  word_status,
  output logic        synced,
  output logic        ta_flag,
  output logic        ta_irq,
  output logic        tc_fast
);
  localparam logic [10:0] GEN = 11'b101_1011_1001;
  localparam int BW = $clog2(WIN + 1);

  function automatic logic [9:0] remx(input int i);
    logic [10:0] r;
    r = 11'd1;
    for (int k = 0; k < i; k++) begin
      r = r << 1;
      if (r[10]) r = r ^ GEN;
    end
    return r[9:0];
  endfunction

  function automatic logic [9:0] syn26(input logic [25:0] w);
    logic [9:0] s;
    s = '0;
    for (int i = 0; i < 26; i++) if (w[i]) s = s ^ remx(i);
    return s;
  endfunction

  function automatic logic [9:0] off(input logic [2:0] k);
    case (k)
      3'd0:    return 10'h0FC;
      3'd1:    return 10'h198;
      3'd2:    return 10'h168;
      3'd3:    return 10'h350;
      default: return 10'h1B4;
    endcase
  endfunction

  function automatic logic [2:0] nxt(input logic [2:0] k);
    case (k)
      3'd0:       return 3'd1;
      3'd1:       return 3'd2;
      3'd2, 3'd3: return 3'd4;
      default:    return 3'd0;
    endcase
  endfunction

  function automatic logic [25:0] find_burst(input logic [9:0] es, input logic [25:0] badm);
    logic [25:0] res, m;
    logic [9:0] s;
    res = '0;
    for (int p = 0; p < 26; p++)
      for (int pat = 1; pat < (1 << BURST); pat += 2) begin
        m = 26'(pat) << p;
        s = '0;
        for (int j = 0; j < BURST; j++)
          if (pat[j] && (p + j) < 26) s = s ^ remx(p + j);
        if (res == '0 && es != '0 && (m & ~badm) == '0 && s == es) res = m;
      end
    return res;
  endfunction

  logic [25:0] sr, bq, nsr, nbad, m1, m2, fix, fixed;
  logic [9:0]  syn, e1, e2;
  logic [4:0]  cnt;
  logic        cand, cslot, hit, conf_ok, ta_src;
  logic [2:0]  ctype, hit_id, sid, conf_id, nexp;
  logic [1:0]  sst;
  logic [WIN-1:0] hist;
  logic [BW-1:0]  bad_cnt;
  logic [BW:0]    bad_nx;

  assign nsr   = {sr[24:0], bit_in};
  assign nbad  = {bq[24:0], bit_bad};
  assign syn   = syn26(nsr);
  assign cslot = (ctype == 3'd2);
  assign e1    = syn ^ off(ctype);
  assign e2    = syn ^ off(3'd3);
  assign m1    = find_burst(e1, nbad);
  assign m2    = cslot ? find_burst(e2, nbad) : '0;
  assign fixed = nsr ^ fix;
  assign nexp  = nxt(ctype);
  assign conf_ok = (syn == off(nexp)) || (nexp == 3'd2 && syn == off(3'd3));
  assign conf_id = (syn == off(nexp)) ? nexp : 3'd3;
  assign bad_nx  = {1'b0, bad_cnt} + (BW+1)'(sst == 2'd2) - (BW+1)'(hist[WIN-1]);

  always_comb begin
    hit = 1'b0;
    hit_id = 3'd0;
    for (int k = 4; k >= 0; k--)
      if (syn == off(3'(k))) begin
        hit = 1'b1;
        hit_id = 3'(k);
      end
  end

  always_comb begin
    sid = ctype;
    sst = 2'd2;
    fix = '0;
    if (e1 == '0) sst = 2'd0;
    else if (cslot && e2 == '0) begin sid = 3'd3; sst = 2'd0; end
    else if (m1 != '0) begin sst = 2'd1; fix = m1; end
    else if (m2 != '0) begin sid = 3'd3; sst = 2'd1; fix = m2; end
  end

  assign ta_src = (fixed[25:21] == 5'b00000) || (fixed[25:21] == 5'b00001) ||
                  (fixed[25:21] == 5'b11111);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0; bq <= '0; cnt <= '0; cand <= 1'b0; ctype <= '0;
      synced <= 1'b0; hist <= '0; bad_cnt <= '0;
      word_valid <= 1'b0; word_data <= '0; word_id <= '0; word_status <= '0;
      ta_flag <= 1'b0; ta_irq <= 1'b0; tc_fast <= 1'b0;
    end else if (soft_rst) begin
      synced <= 1'b0; cand <= 1'b0; cnt <= '0; hist <= '0; bad_cnt <= '0;
      word_valid <= 1'b0; ta_irq <= 1'b0; tc_fast <= 1'b1;
    end else begin
      word_valid <= 1'b0;
      ta_irq <= 1'b0;
      tc_fast <= 1'b0;
      if (bit_valid) begin
        sr <= nsr;
        bq <= nbad;
        if (synced) begin
          if (cnt == 5'd25) begin
            cnt <= '0;
            word_valid <= 1'b1;
            word_data <= fixed[25:10];
            word_id <= sid;
            word_status <= sst;
            ctype <= nxt(sid);
            if (sid == 3'd1 && sst != 2'd2 && ta_src) begin
              ta_flag <= fixed[14];
              ta_irq <= (fixed[14] != ta_flag);
            end
            if (bad_nx > (BW+1)'(MAX_BAD)) begin
              synced <= 1'b0; cand <= 1'b0; hist <= '0; bad_cnt <= '0; tc_fast <= 1'b1;
            end else begin
              hist <= {hist[WIN-2:0], sst == 2'd2};
              bad_cnt <= bad_nx[BW-1:0];
            end
          end else cnt <= cnt + 5'd1;
        end else if (cand && cnt == 5'd25) begin
          cnt <= '0;
          if (conf_ok) begin
            synced <= 1'b1; cand <= 1'b0; hist <= '0; bad_cnt <= '0;
            word_valid <= 1'b1;
            word_data <= nsr[25:10];
            word_id <= conf_id;
            word_status <= 2'd0;
            ctype <= nxt(conf_id);
            if (conf_id == 3'd1 && ta_src) begin
              ta_flag <= nsr[14];
              ta_irq <= (nsr[14] != ta_flag);
            end
          end else if (hit) ctype <= hit_id;
          else cand <= 1'b0;
        end else if (cand) cnt <= cnt + 5'd1;
        else if (hit) begin
          cand <= 1'b1; ctype <= hit_id; cnt <= '0;
        end
      end
    end
  end

  // R3
  legal_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (word_status != 2'd3 && word_id <= 3'd4));
  // R8
  resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!synced && tc_fast));
  // R6
  flywheel_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    synced |-> bad_cnt <= BW'(MAX_BAD));
  // R7
  ta_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ta_irq |-> ta_flag != $past(ta_flag));
  // R1
  sync_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced) |-> (word_valid && word_status == 2'd0));
  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 5'd25);
endmodule

// File: tb/test_rds_sync.sv
module test_rds_sync;
  localparam int PERIOD = 10;
  localparam logic [10:0] G = 11'b101_1011_1001;

  logic clk = 1'b0, rst_n = 1'b0, bit_valid = 1'b0, bit_in = 1'b0, bit_bad = 1'b0, soft_rst = 1'b0;
  logic word_valid, synced, ta_flag, ta_irq, tc_fast;
  logic [15:0] word_data;
  logic [2:0] word_id;
  logic [1:0] word_status;

  int checks = 0, errors = 0, words = 0, irqs = 0, tcs = 0;
  logic [15:0] l_data;
  logic [2:0] l_id;
  logic [1:0] l_st;

  rds_sync i_rds_sync (.clk, .rst_n, .bit_valid, .bit_in, .bit_bad, .soft_rst,
    .word_valid, .word_data, .word_id, .word_status, .synced, .ta_flag, .ta_irq, .tc_fast);

  always #(PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (word_valid) begin words++; l_data = word_data; l_id = word_id; l_st = word_status; end
    if (ta_irq) irqs++;
    if (tc_fast) tcs++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] offw(input int k);
    case (k)
      0: return 10'h0FC;
      1: return 10'h198;
      2: return 10'h168;
      3: return 10'h350;
      default: return 10'h1B4;
    endcase
  endfunction

  function automatic logic [25:0] enc(input logic [15:0] info, input int k);
    logic [25:0] r;
    r = {info, 10'b0};
    for (int i = 25; i >= 10; i--) if (r[i]) r = r ^ (26'(G) << (i - 10));
    return {info, r[9:0] ^ offw(k)};
  endfunction

  task automatic send(input logic [15:0] info, input int k, input logic [25:0] flip,
                      input logic [25:0] badm);
    logic [25:0] cw;
    cw = enc(info, k) ^ flip;
    for (int i = 25; i >= 0; i--) begin
      @(negedge clk);
      bit_valid = 1'b1; bit_in = cw[i]; bit_bad = badm[i];
    end
    @(negedge clk);
    bit_valid = 1'b0; bit_bad = 1'b0;
    #1;
  endtask

  task automatic pulse_soft;
    int t0;
    t0 = tcs;
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    #1;
    chk("R8 tc_fast after resync", tcs - t0, 1);
    chk("R8 not aligned after resync", synced, 0);
  endtask

  task automatic t_reset;
    chk("R9 synced", synced, 0);
    chk("R9 word_valid", word_valid, 0);
    chk("R9 ta_flag", ta_flag, 0);
    chk("R9 tc_fast", tc_fast, 0);
  endtask

  task automatic t_order;
    int w0;
    w0 = words;
    send(16'h1111, 0, '0, '0);
    send(16'h2222, 2, '0, '0);
    chk("R2 no alignment out of order", synced, 0);
    chk("R2 no word", words - w0, 0);
  endtask

  task automatic t_acquire;
    pulse_soft();
    send(16'h1234, 0, '0, '0);
    send(16'h5A00, 1, '0, '0);
    chk("R1 aligned", synced, 1);
    chk("R1 id", l_id, 1);
    chk("R1 status", l_st, 0);
    chk("R1 data", l_data, 16'h5A00);
  endtask

  task automatic t_words;
    send(16'hBEEF, 3, '0, '0);
    chk("R10 id C'", l_id, 3);
    chk("R10 data", l_data, 16'hBEEF);
    send(16'hC0DE, 4, '0, '0);
    chk("R3 id D", l_id, 4);
    chk("R3 status", l_st, 0);
    chk("R3 data", l_data, 16'hC0DE);
  endtask

  task automatic t_correct;
    send(16'h6789, 0, 26'h5 << 13, 26'h1F << 12);
    chk("R4 status corrected", l_st, 1);
    chk("R4 data restored", l_data, 16'h6789);
    chk("R4 id", l_id, 0);
  endtask

  task automatic t_ta;
    int i0;
    i0 = irqs;
    send(16'h0010, 1, '0, '0);
    chk("R7 ta_flag set", ta_flag, 1);
    chk("R7 one event", irqs - i0, 1);
    send(16'h0000, 2, '0, '0);
    chk("R3 id C", l_id, 2);
  endtask

  task automatic t_uncorr;
    send(16'hA5A5, 4, 26'h50, 26'h10);
    chk("R5 status uncorrectable", l_st, 2);
    chk("R5 data passed", l_data, 16'hA5A5);
  endtask

  task automatic t_flywheel;
    int k, t0;
    pulse_soft();
    send(16'h0101, 0, '0, '0);
    send(16'h0202, 1, '0, '0);
    chk("R1 aligned again", synced, 1);
    k = 2;
    for (int n = 0; n < 20; n++) begin
      send(16'h3300, k, 26'h208, '0);
      k = (k == 2) ? 4 : (k == 4) ? 0 : (k == 0) ? 1 : 2;
    end
    chk("R6 held through 20 bad", synced, 1);
    chk("R6 bad status", l_st, 2);
    t0 = tcs;
    send(16'h3300, k, 26'h208, '0);
    chk("R6 dropped at 21", synced, 0);
    chk("R8 tc_fast on loss", tcs - t0, 1);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_order();
    t_acquire();
    t_words();
    t_correct();
    t_ta();
    t_uncorr();
    t_flywheel();
    finish_run();
  end
endmodule